// File: doc/BRIEF.md
# Line-Gated Caption Byte Acquisition

This block takes an already sliced serial bit stream from the caption line of a 525-line video signal and turns it into a pair of 8-bit caption bytes. For each video line it receives a start strobe that marks the first data bit, a bit-valid strobe with its data bit, the line number, a field flag and an end-of-line strobe. Capture happens only on lines that pass a programmable gate. The gate is controlled by a field-select bit, a window-width bit and an acquisition inhibit bit.

Sixteen bits are collected least significant bit first. Each byte is checked for odd parity. Each byte is stored with its seven data bits in positions 0 to 6 and a parity error flag in position 7, which takes the place of the received parity bit. When a pair is complete, the stored bytes and the field indicator are updated and a one-cycle new-data pulse is raised. A line that ends before its sixteenth bit leaves no trace.

The controller has three states. ST_IDLE waits for a qualifying line. ST_SHIFT collects bits. ST_HOLD ignores the rest of a line once its pair is complete. The transitions are:
- T_START: line_start together with bit_valid on a qualifying line moves the block into ST_SHIFT from any state.
- T_FULL: the sixteenth accepted bit moves ST_SHIFT to ST_HOLD and reports the pair.
- T_ABORT: acquisition inhibit, line_end, or a line_start on a line that does not qualify returns any state to ST_IDLE.

Top module: `ccb_acq`

## Requirements
- R1: After reset pair_lo, pair_hi, new_data and data_field2 are all 0.
- R2: With cfg_wide = 0, a line is captured only when line_num is 21 and field_is2 equals cfg_field2 (0 selects field 1, 1 selects field 2).
- R3: With cfg_wide = 1, lines 19 to 23 of either field are captured and cfg_field2 is ignored; other line numbers are not captured.
- R4: While cfg_acq_off is 1 nothing is captured, new_data stays 0 and the held bytes and field flag do not change.
- R5: Bits arrive least significant bit first; the first eight accepted bits form pair_lo and the next eight form pair_hi. Received bits 0 to 6 appear in stored bit positions 0 to 6.
- R6: Bit 7 of each stored byte is 1 when its eight received bits hold an even number of ones (odd parity failed), and 0 otherwise.
- R7: new_data is high for exactly the one cycle after the clock edge that samples the sixteenth bit. The bytes and data_field2 update at that same edge, and data_field2 is the field_is2 value sampled with the line's start strobe (1 = field 2).
- R8: A line whose line_end arrives before the sixteenth bit raises no new_data and leaves the held outputs unchanged. A bit presented in the same cycle as line_end is dropped.
- R9: Bits after the sixteenth on the same line are ignored and cause no further pulse.
- R10: A newly completed pair replaces the held pair even when the previous pair has not been consumed.
- R11: line_start with bit_valid marks bit 0 of a line. A start during a capture discards the partial bits and begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Sliced data bit strobe |
| bit_data | input | 1 | Sliced data bit |
| line_start | input | 1 | With bit_valid, marks the first data bit of a line |
| line_end | input | 1 | End of the current video line |
| line_num | input | LINE_W | Line number within the field |
| field_is2 | input | 1 | 1 while field 2 is being received |
| cfg_field2 | input | 1 | Field select for the narrow window |
| cfg_wide | input | 1 | 0: line 21 only; 1: lines 19 to 23 of both fields |
| cfg_acq_off | input | 1 | Inhibits all capture |
| pair_lo | output | 8 | First stored byte (error flag in bit 7) |
| pair_hi | output | 8 | Second stored byte (error flag in bit 7) |
| new_data | output | 1 | One-cycle pulse when a pair has been stored |
| data_field2 | output | 1 | Field of the stored pair |

## Verification
The main function is tried with good pairs on line 21 in each field under both field-select values. It is also tried with lines 19, 20, 23 and 24 under both window settings, which separates the narrow-window field check from the wide-window line range. Bytes with deliberately broken parity separate the error-flag position and polarity from the data bits. Line shapes that are truncated, ended on the sixteenth bit, overrun to 24 bits, or restarted mid-capture tell apart the discard, precedence, ignore and restart rules. A per-clock behavioural model compares all four outputs on every cycle.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } acq_state_t;
endpackage

// File: rtl/ccb_line_gate.sv
module ccb_line_gate #(
    parameter int LINE_W    = 10,
    parameter int CAP_LINE  = 21,
    parameter int WIN_FIRST = 19,
    parameter int WIN_LAST  = 23
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_is2,
    input  logic              sel_field2,
    input  logic              wide_win,
    output logic              line_ok
);
    localparam logic [LINE_W-1:0] L_CAP = LINE_W'(CAP_LINE);
    localparam logic [LINE_W-1:0] L_LO  = LINE_W'(WIN_FIRST);
    localparam logic [LINE_W-1:0] L_HI  = LINE_W'(WIN_LAST);

    always_comb begin
        if (wide_win) begin
            line_ok = (line_num >= L_LO) && (line_num <= L_HI);
        end else begin
            line_ok = (line_num == L_CAP) && (field_is2 == sel_field2);
        end
    end
endmodule

// File: rtl/ccb_shifter.sv
module ccb_shifter #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             take,
    input  logic             din,
    output logic [NBITS-1:0] word_nxt,
    output logic             last_bit
);
    localparam int CNT_W = $clog2(NBITS + 1);

    logic [NBITS-1:0] sr;
    logic [CNT_W-1:0] cnt;

    assign word_nxt = {din, sr[NBITS-1:1]};
    assign last_bit = (cnt == CNT_W'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (restart) begin
            sr  <= word_nxt;
            cnt <= CNT_W'(1);
        end else if (take) begin
            sr  <= word_nxt;
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R9
    take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt < CNT_W'(NBITS)));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/ccb_byte_pack.sv
module ccb_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] raw,
    output logic [BYTE_W-1:0] byte_out
);
    // odd parity expected: an even count of ones marks an error
    assign byte_out = {~^raw, raw[BYTE_W-2:0]};
endmodule

// File: rtl/ccb_acq.sv
module ccb_acq
    import ccb_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int CAP_LINE  = 21,
    parameter int WIN_FIRST = 19,
    parameter int WIN_LAST  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              line_start,
    input  logic              line_end,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_is2,
    input  logic              cfg_field2,
    input  logic              cfg_wide,
    input  logic              cfg_acq_off,
    output logic [7:0]        pair_lo,
    output logic [7:0]        pair_hi,
    output logic              new_data,
    output logic              data_field2
);
    localparam int BYTE_W = 8;
    localparam int NBYTES = 2;
    localparam int NBITS  = NBYTES * BYTE_W;

    acq_state_t       state, state_nxt;
    logic             line_ok;
    logic             last_bit;
    logic             start_hit;
    logic             take;
    logic             report;
    logic             cur_f2;
    logic [NBITS-1:0] word_nxt;
    logic [NBITS-1:0] packed_all;
    logic [NBITS-1:0] pair_q;

    ccb_line_gate #(
        .LINE_W(LINE_W), .CAP_LINE(CAP_LINE),
        .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
    ) u_gate (
        .line_num  (line_num),
        .field_is2 (field_is2),
        .sel_field2(cfg_field2),
        .wide_win  (cfg_wide),
        .line_ok   (line_ok)
    );

    assign start_hit = line_start && bit_valid && line_ok && !line_end && !cfg_acq_off;
    assign take      = bit_valid && (state == ST_SHIFT) && !line_start && !line_end && !cfg_acq_off;
    assign report    = take && last_bit;

    ccb_shifter #(.NBITS(NBITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_hit),
        .take    (take),
        .din     (bit_data),
        .word_nxt(word_nxt),
        .last_bit(last_bit)
    );

    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
        ccb_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
            .raw     (word_nxt[g*BYTE_W +: BYTE_W]),
            .byte_out(packed_all[g*BYTE_W +: BYTE_W])
        );
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (cfg_acq_off || line_end) begin
            state_nxt = ST_IDLE;                          // T_ABORT
        end else if (line_start && bit_valid) begin
            state_nxt = line_ok ? ST_SHIFT : ST_IDLE;     // T_START / T_ABORT
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_SHIFT: if (report) state_nxt = ST_HOLD; // T_FULL
                ST_HOLD:  state_nxt = ST_HOLD;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_f2      <= 1'b0;
            pair_q      <= '0;
            new_data    <= 1'b0;
            data_field2 <= 1'b0;
        end else begin
            if (start_hit) cur_f2 <= field_is2;
            new_data <= report;
            if (report) begin
                pair_q      <= packed_all;
                data_field2 <= cur_f2;
            end
        end
    end

    assign pair_lo = pair_q[BYTE_W-1:0];
    assign pair_hi = pair_q[NBITS-1:BYTE_W];

    // R4
    acq_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_acq_off |=> !new_data);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |=> !new_data);

    // R7
    report_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |-> $past(bit_valid));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !new_data);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_data |-> ($stable(pair_q) && $stable(data_field2)));
endmodule

// File: tb/ccb_acq_tb.sv
`timescale 1ns/1ps
module ccb_acq_tb;
    localparam int LINE_W = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_valid = 1'b0, bit_data = 1'b0, line_start = 1'b0, line_end = 1'b0;
    logic field_is2 = 1'b0, cfg_field2 = 1'b0, cfg_wide = 1'b0, cfg_acq_off = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic [7:0] pair_lo, pair_hi;
    logic new_data, data_field2;

    always #2 clk = ~clk;

    ccb_acq #(.LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .line_start(line_start), .line_end(line_end), .line_num(line_num),
        .field_is2(field_is2), .cfg_field2(cfg_field2), .cfg_wide(cfg_wide),
        .cfg_acq_off(cfg_acq_off), .pair_lo(pair_lo), .pair_hi(pair_hi),
        .new_data(new_data), .data_field2(data_field2)
    );

    int checks = 0, fails = 0, pulses = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 1'b0, armed = 1'b0;

    // behavioural reference model
    int m_state = 0;
    bit m_q[$];
    logic [7:0] m_lo = '0, m_hi = '0;
    bit m_nd = 0, m_f2 = 0, m_line_f2 = 0;

    function automatic bit gate_ok(int ln, bit f2);
        if (cfg_wide) return (ln >= 19) && (ln <= 23);
        return (ln == 21) && (f2 == cfg_field2);
    endfunction

    function automatic logic [7:0] ref_byte(int base);
        int ones = 0;
        logic [7:0] v = '0;
        for (int j = 0; j < 8; j++) begin
            if (m_q[base+j]) ones++;
            if (j < 7) v[j] = m_q[base+j];
        end
        v[7] = (ones % 2 == 0);
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        armed = 1'b1;
        m_nd = 0;
        if (!rst_n) begin
            m_state = 0; m_q.delete(); m_lo = '0; m_hi = '0; m_f2 = 0;
        end else if (cfg_acq_off || line_end) begin
            m_state = 0;
        end else if (line_start && bit_valid) begin
            if (gate_ok(int'(line_num), field_is2)) begin
                m_q.delete(); m_q.push_back(bit_data);
                m_line_f2 = field_is2; m_state = 1;
            end else m_state = 0;
        end else if (bit_valid && m_state == 1) begin
            m_q.push_back(bit_data);
            if (m_q.size() == 16) begin
                m_lo = ref_byte(0); m_hi = ref_byte(8);
                m_f2 = m_line_f2; m_nd = 1; m_state = 2;
            end
        end
    end

    always @(negedge clk) if (armed && !done) begin
        checks++;
        if (new_data) pulses++;
        if ({pair_lo, pair_hi, new_data, data_field2} !== {m_lo, m_hi, m_nd, m_f2}) begin
            fails++;
            $display("FAIL %s: lo=%02h hi=%02h nd=%0b f2=%0b expected lo=%02h hi=%02h nd=%0b f2=%0b",
                     cur_req, pair_lo, pair_hi, new_data, data_field2, m_lo, m_hi, m_nd, m_f2);
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // two bytes with odd parity unless a bad flag is set
    function automatic logic [15:0] pair_bits(logic [6:0] a, logic [6:0] b, bit bad_a, bit bad_b);
        logic pa, pb;
        pa = (~^a) ^ bad_a;
        pb = (~^b) ^ bad_b;
        return {pb, b, pa, a};
    endfunction

    task automatic send_line(int ln, bit f2, int nbits, logic [31:0] pat, bit end_on_last, bit no_end);
        @(negedge clk);
        line_num = LINE_W'(ln); field_is2 = f2;
        for (int i = 0; i < nbits; i++) begin
            bit_valid = 1'b1; bit_data = pat[i]; line_start = (i == 0);
            line_end = end_on_last && (i == nbits - 1);
            @(negedge clk);
            bit_valid = 1'b0; line_start = 1'b0; line_end = 1'b0;
            if (i % 3 == 2) @(negedge clk);
        end
        if (!end_on_last && !no_end) begin
            line_end = 1'b1; @(negedge clk); line_end = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        check_eq("R1", "pair_lo", pair_lo, 0);
        check_eq("R1", "pair_hi", pair_hi, 0);
        check_eq("R1", "new_data", new_data, 0);
        check_eq("R1", "data_field2", data_field2, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R7: field 1, line 21, narrow window
        cur_req = "R2"; pulses = 0;
        send_line(21, 0, 16, {16'h0, pair_bits(7'h41, 7'h2C, 0, 0)}, 0, 0);
        check_eq("R2", "pulses", pulses, 1);
        check_eq("R5", "pair_lo", pair_lo, 8'h41);
        check_eq("R5", "pair_hi", pair_hi, 8'h2C);
        check_eq("R7", "data_field2", data_field2, 0);

        // R2: wrong field and wrong line rejected
        pulses = 0;
        send_line(21, 1, 16, {16'h0, pair_bits(7'h11, 7'h22, 0, 0)}, 0, 0);
        send_line(20, 0, 16, {16'h0, pair_bits(7'h11, 7'h22, 0, 0)}, 0, 0);
        check_eq("R2", "pulses rejected", pulses, 0);
        check_eq("R2", "pair_lo kept", pair_lo, 8'h41);

        // R2 R7: field 2 selected
        cfg_field2 = 1'b1; pulses = 0;
        send_line(21, 1, 16, {16'h0, pair_bits(7'h7F, 7'h00, 0, 0)}, 0, 0);
        check_eq("R2", "pulses f2", pulses, 1);
        check_eq("R7", "data_field2", data_field2, 1);
        check_eq("R5", "pair_lo f2", pair_lo, 8'h7F);

        // R3: wide window
        cur_req = "R3"; cfg_wide = 1'b1; pulses = 0;
        send_line(19, 0, 16, {16'h0, pair_bits(7'h05, 7'h0A, 0, 0)}, 0, 0);
        check_eq("R3", "data_field2 line19", data_field2, 0);
        send_line(23, 1, 16, {16'h0, pair_bits(7'h33, 7'h44, 0, 0)}, 0, 0);
        check_eq("R3", "pair_hi line23", pair_hi, 8'h44);
        send_line(24, 1, 16, {16'h0, pair_bits(7'h55, 7'h66, 0, 0)}, 0, 0);
        check_eq("R3", "pulses wide", pulses, 2);
        cfg_wide = 1'b0; cfg_field2 = 1'b0;

        // R6: parity errors
        cur_req = "R6"; pulses = 0;
        send_line(21, 0, 16, {16'h0, pair_bits(7'h41, 7'h2C, 1, 0)}, 0, 0);
        check_eq("R6", "pair_lo bad", pair_lo, 8'hC1);
        check_eq("R6", "pair_hi good", pair_hi, 8'h2C);
        send_line(21, 0, 16, {16'h0, pair_bits(7'h00, 7'h01, 0, 1)}, 0, 0);
        check_eq("R6", "pair_hi bad", pair_hi, 8'h81);
        check_eq("R6", "pair_lo zero", pair_lo, 8'h00);

        // R4: acquisition off
        cur_req = "R4"; cfg_acq_off = 1'b1; pulses = 0;
        send_line(21, 0, 16, {16'h0, pair_bits(7'h12, 7'h34, 0, 0)}, 0, 0);
        check_eq("R4", "pulses", pulses, 0);
        check_eq("R4", "pair_hi kept", pair_hi, 8'h81);
        cfg_acq_off = 1'b0;

        // R8: partial line and line_end on the sixteenth bit
        cur_req = "R8"; pulses = 0;
        send_line(21, 0, 10, {16'h0, pair_bits(7'h12, 7'h34, 0, 0)}, 0, 0);
        send_line(21, 0, 16, {16'h0, pair_bits(7'h12, 7'h34, 0, 0)}, 1, 0);
        check_eq("R8", "pulses", pulses, 0);
        check_eq("R8", "pair_lo kept", pair_lo, 8'h00);

        // R9: overrun bits ignored
        cur_req = "R9"; pulses = 0;
        send_line(21, 0, 24, {8'h0, 8'hFF, pair_bits(7'h21, 7'h43, 0, 0)}, 0, 0);
        check_eq("R9", "pulses", pulses, 1);
        check_eq("R9", "pair_lo", pair_lo, 8'h21);
        check_eq("R9", "pair_hi", pair_hi, 8'h43);

        // R10: back-to-back overwrite
        cur_req = "R10"; pulses = 0;
        send_line(21, 0, 16, {16'h0, pair_bits(7'h0F, 7'h70, 0, 0)}, 0, 0);
        send_line(21, 0, 16, {16'h0, pair_bits(7'h3C, 7'h03, 0, 0)}, 0, 0);
        check_eq("R10", "pulses", pulses, 2);
        check_eq("R10", "pair_lo", pair_lo, 8'h3C);

        // R11: restart mid-capture
        cur_req = "R11"; pulses = 0;
        send_line(21, 0, 9, {16'h0, pair_bits(7'h7E, 7'h7E, 0, 0)}, 0, 1);
        send_line(21, 0, 16, {16'h0, pair_bits(7'h19, 7'h62, 0, 0)}, 0, 0);
        check_eq("R11", "pulses", pulses, 1);
        check_eq("R11", "pair_lo", pair_lo, 8'h19);
        check_eq("R11", "pair_hi", pair_hi, 8'h62);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog %s: cycles=%0d expected below 20000", cur_req, cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule